// File: doc/BRIEF.md
# Variable-Length Instruction Word Sequencer and Field Decoder

This block sits between an instruction-word source and the rest of a processor front end. It accepts 16-bit instruction words, one per cycle, whenever the source flags a word as valid. From the first word of each instruction it decides whether a second 16-bit word (an immediate, an absolute address or a branch target) must follow. If so, it holds the first word and waits for the next valid word before it releases anything.

Each finished instruction comes out as a registered bundle with a one-cycle valid strobe. The bundle holds the five raw fields, an instruction class, an addressing-mode code, a shift amount and the extension word when there is one. Fetching operands, touching memory and executing the instruction are all handled downstream.

Top module: `vfd_top`

## Requirements
- R1: The first word is split as op0 = bits [15:12], regA = bits [11:9], op1 = bits [8:6], opn = bits [5:3], regB = bits [2:0]. These fields appear unchanged on decOp0, decRegA, decOp1, decOpn and decRegB.
- R2: When the class is ALU, op1 = 4 and opn is 1, 2 or 3, the next valid word is captured on decImm and decExt is 1. The mode code is 6 for opn 1, 7 for opn 2 and 8 for opn 3.
- R3: When op0 = 0xF and op1 is 1 or 2, the instruction is two words long. The next valid word appears on decImm and decExt is 1.
- R4: Class codes on decClass are: 2 (special) when op0 = 0xF; otherwise 1 (jump) when regA = 7; otherwise 3 (stack list) when op1 = 2; otherwise 0 (ALU).
- R5: For the ALU and stack-list classes, the mode code on decMode follows op1: 0 gives 1 (base-pointer offset), 1 gives 2 (short immediate), 2 gives 3 (register list), 3 gives 4 (register indirect, with the variant in opn), 7 gives 14 (short absolute address), and 4 with opn 0 gives 5 (register).
- R6: The shift modes are: op1 = 4 with opn 4..7 gives 9 (arithmetic right); op1 = 5 gives 10 (left) for opn 0..3 and 11 (logical right) for opn 4..7; op1 = 6 gives 12 (rotate left) for opn 0..3 and 13 (rotate right) for opn 4..7. For these modes decShift = opn[1:0] + 1. For every other mode decShift = 0.
- R7: decValid is high for exactly one cycle, in the cycle after the final word of an instruction is accepted. It stays low while a second word is awaited, however many idle cycles pass before that word arrives.
- R8: A synchronous reset clears decValid and drops any half-received instruction. The next valid word is then treated as a first word.
- R9: For single-word instructions, decExt is 0 and decImm is 0. For the jump and special classes, decMode is 0. A jump never takes a second word, whatever its op1 and opn bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wordValid | input | 1 | wordIn carries a word this cycle |
| wordIn | input | 16 | Instruction or extension word |
| decValid | output | 1 | Decoded bundle valid strobe |
| decOp0 | output | 4 | Primary opcode field |
| decRegA | output | 3 | Operand A field |
| decOp1 | output | 3 | Secondary opcode / mode field |
| decOpn | output | 3 | OPN parameter field |
| decRegB | output | 3 | Operand B field |
| decClass | output | 2 | Instruction class code |
| decMode | output | 4 | Addressing-mode code |
| decShift | output | 3 | Shift amount (0 when not a shift) |
| decExt | output | 1 | Instruction carried a second word |
| decImm | output | 16 | Second word, or 0 |

## Verification
The assertions check the following on every cycle:
- each valid strobe follows an accepted word;
- the branch-target forms always report an extension;
- jumps never report an extension;
- an extension value equals the word taken one cycle earlier;
- a reset clears the strobe;
- arithmetic-right shifts only come from opn values 4 to 7.

Only the bench's scenarios can show the rest:
- the output is withheld while a second word is awaited across idle cycles;
- a reset in the middle of an instruction discards the pending first word;
- the exact class, mode and shift codes for each encoding are correct.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  parameter int WORD_W = 16;
  parameter int OP0_W  = 4;
  parameter int FLD_W  = 3;
  localparam int SHIFT_W = FLD_W;

  typedef enum logic [1:0] {
    CLS_ALU     = 2'd0,
    CLS_JUMP    = 2'd1,
    CLS_SPECIAL = 2'd2,
    CLS_STACK   = 2'd3
  } instClass_t;

  typedef enum logic [3:0] {
    MODE_NONE    = 4'd0,
    MODE_BPOFF   = 4'd1,
    MODE_IMM6    = 4'd2,
    MODE_LIST    = 4'd3,
    MODE_INDIR   = 4'd4,
    MODE_REG     = 4'd5,
    MODE_IMM16   = 4'd6,
    MODE_FROMABS = 4'd7,
    MODE_TOABS   = 4'd8,
    MODE_ASR     = 4'd9,
    MODE_LSL     = 4'd10,
    MODE_LSR     = 4'd11,
    MODE_ROL     = 4'd12,
    MODE_ROR     = 4'd13,
    MODE_ABS6    = 4'd14
  } addrMode_t;

  typedef struct packed {
    logic loadFirst;
    logic useSaved;
    logic emit;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [OP0_W-1:0]   op0;
    logic [FLD_W-1:0]   regA;
    logic [FLD_W-1:0]   op1;
    logic [FLD_W-1:0]   opn;
    logic [FLD_W-1:0]   regB;
    instClass_t         cls;
    addrMode_t          mode;
    logic [SHIFT_W-1:0] shiftAmt;
    logic               needsExt;
  } fieldInfo_t;
endpackage

// File: rtl/vfd_field_decode.sv
module vfd_field_decode
  import vfd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fieldInfo_t        info
);
  localparam logic [OP0_W-1:0] SPECIAL_OP = '1;
  localparam logic [FLD_W-1:0] PC_REG     = '1;

  logic isShift;

  always_comb begin
    info.op0  = word[WORD_W-1 -: OP0_W];
    info.regA = word[WORD_W-OP0_W-1 -: FLD_W];
    info.op1  = word[3*FLD_W-1 -: FLD_W];
    info.opn  = word[2*FLD_W-1 -: FLD_W];
    info.regB = word[FLD_W-1:0];

    if (info.op0 == SPECIAL_OP)      info.cls = CLS_SPECIAL;
    else if (info.regA == PC_REG)    info.cls = CLS_JUMP;
    else if (info.op1 == 3'd2)       info.cls = CLS_STACK;
    else                             info.cls = CLS_ALU;

    info.mode = MODE_NONE;
    if (info.cls == CLS_ALU || info.cls == CLS_STACK) begin
      case (info.op1)
        3'd0: info.mode = MODE_BPOFF;
        3'd1: info.mode = MODE_IMM6;
        3'd2: info.mode = MODE_LIST;
        3'd3: info.mode = MODE_INDIR;
        3'd4: begin
          case (info.opn)
            3'd0:    info.mode = MODE_REG;
            3'd1:    info.mode = MODE_IMM16;
            3'd2:    info.mode = MODE_FROMABS;
            3'd3:    info.mode = MODE_TOABS;
            default: info.mode = MODE_ASR;
          endcase
        end
        3'd5: info.mode = info.opn[FLD_W-1] ? MODE_LSR : MODE_LSL;
        3'd6: info.mode = info.opn[FLD_W-1] ? MODE_ROR : MODE_ROL;
        default: info.mode = MODE_ABS6;
      endcase
    end

    isShift = (info.mode == MODE_ASR) || (info.mode == MODE_LSL) ||
              (info.mode == MODE_LSR) || (info.mode == MODE_ROL) ||
              (info.mode == MODE_ROR);
    info.shiftAmt = isShift ? ({1'b0, info.opn[1:0]} + SHIFT_W'(1)) : '0;

    info.needsExt = (info.mode == MODE_IMM16) || (info.mode == MODE_FROMABS) ||
                    (info.mode == MODE_TOABS) ||
                    (info.cls == CLS_SPECIAL && (info.op1 == 3'd1 || info.op1 == 3'd2));
  end
endmodule

// File: rtl/vfd_ctrl.sv
module vfd_ctrl
  import vfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wordValid,
  input  logic        needsExt,
  output ctrlStrobe_t strobe
);
  typedef enum logic {WAIT_FIRST, WAIT_SECOND} seqState_t;
  seqState_t state;

  always_comb begin
    strobe.loadFirst = (state == WAIT_FIRST) && wordValid;
    strobe.useSaved  = (state == WAIT_SECOND);
    strobe.emit      = wordValid && ((state == WAIT_SECOND) || !needsExt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WAIT_FIRST;
    end else if (wordValid) begin
      state <= (state == WAIT_FIRST && needsExt) ? WAIT_SECOND : WAIT_FIRST;
    end
  end
endmodule

// File: rtl/vfd_datapath.sv
module vfd_datapath
  import vfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wordIn,
  input  ctrlStrobe_t       strobe,
  output logic              needsExt,
  output fieldInfo_t        outInfo,
  output logic [WORD_W-1:0] outImm,
  output logic              outHasExt,
  output logic              outValid
);
  logic [WORD_W-1:0] savedWord;
  logic [WORD_W-1:0] srcWord;
  fieldInfo_t        info;

  assign srcWord  = strobe.useSaved ? savedWord : wordIn;
  assign needsExt = info.needsExt;

  vfd_field_decode u_dec (
    .word (srcWord),
    .info (info)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      savedWord <= '0;
      outInfo   <= '0;
      outImm    <= '0;
      outHasExt <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.loadFirst) savedWord <= wordIn;
      if (strobe.emit) begin
        outInfo   <= info;
        outImm    <= strobe.useSaved ? wordIn : '0;
        outHasExt <= strobe.useSaved;
      end
    end
  end
endmodule

// File: rtl/vfd_top.sv
module vfd_top
  import vfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  output logic              decValid,
  output logic [OP0_W-1:0]  decOp0,
  output logic [FLD_W-1:0]  decRegA,
  output logic [FLD_W-1:0]  decOp1,
  output logic [FLD_W-1:0]  decOpn,
  output logic [FLD_W-1:0]  decRegB,
  output logic [1:0]        decClass,
  output logic [3:0]        decMode,
  output logic [SHIFT_W-1:0] decShift,
  output logic              decExt,
  output logic [WORD_W-1:0] decImm
);
  ctrlStrobe_t strobe;
  fieldInfo_t  outInfo;
  logic        needsExt;

  vfd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wordValid (wordValid),
    .needsExt  (needsExt),
    .strobe    (strobe)
  );

  vfd_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .wordIn    (wordIn),
    .strobe    (strobe),
    .needsExt  (needsExt),
    .outInfo   (outInfo),
    .outImm    (decImm),
    .outHasExt (decExt),
    .outValid  (decValid)
  );

  assign decOp0   = outInfo.op0;
  assign decRegA  = outInfo.regA;
  assign decOp1   = outInfo.op1;
  assign decOpn   = outInfo.opn;
  assign decRegB  = outInfo.regB;
  assign decClass = outInfo.cls;
  assign decMode  = outInfo.mode;
  assign decShift = outInfo.shiftAmt;
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker
  import vfd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordIn,
  input logic              decValid,
  input logic [FLD_W-1:0]  decOp1,
  input logic [FLD_W-1:0]  decOpn,
  input logic [1:0]        decClass,
  input logic [3:0]        decMode,
  input logic [SHIFT_W-1:0] decShift,
  input logic              decExt,
  input logic [WORD_W-1:0] decImm
);
  assert_valid_follows_word_R7: assert property (@(posedge clk) disable iff (rst)
    decValid |-> $past(wordValid));

  assert_branch_target_ext_R3: assert property (@(posedge clk) disable iff (rst)
    (decValid && decClass == 2'd2 && (decOp1 == 3'd1 || decOp1 == 3'd2)) |-> decExt);

  assert_jump_single_word_R9: assert property (@(posedge clk) disable iff (rst)
    (decValid && decClass == 2'd1) |-> (!decExt && decImm == '0));

  assert_imm_is_last_word_R2: assert property (@(posedge clk) disable iff (rst)
    (decValid && decExt) |-> (decImm == $past(wordIn)));

  assert_reset_clears_valid_R8: assert property (@(posedge clk)
    rst |=> !decValid);

  assert_asr_opn_range_R6: assert property (@(posedge clk) disable iff (rst)
    (decValid && decMode == 4'd9) |-> (decOp1 == 3'd4 && decOpn[2] && decShift != '0));
endmodule

bind vfd_top vfd_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .wordValid (wordValid),
  .wordIn    (wordIn),
  .decValid  (decValid),
  .decOp1    (decOp1),
  .decOpn    (decOpn),
  .decClass  (decClass),
  .decMode   (decMode),
  .decShift  (decShift),
  .decExt    (decExt),
  .decImm    (decImm)
);

// File: tb/sim_vfd_top.sv
module sim_vfd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wordValid = 1'b0;
  logic [15:0] wordIn = '0;
  logic        decValid;
  logic [3:0]  decOp0;
  logic [2:0]  decRegA, decOp1, decOpn, decRegB;
  logic [1:0]  decClass;
  logic [3:0]  decMode;
  logic [2:0]  decShift;
  logic        decExt;
  logic [15:0] decImm;

  int checks = 0;
  int errors = 0;
  string curReq = "R8";

  bit          pend = 0;
  logic [15:0] held = '0;
  bit          eValid = 0;
  logic [15:0] eWord = '0;
  logic [15:0] eImm = '0;
  bit          eExt = 0;

  always #2 clk = ~clk;

  vfd_top u0 (.*);

  function automatic logic [15:0] mk(int o0, int a, int o1, int opn, int b);
    return {o0[3:0], a[2:0], o1[2:0], opn[2:0], b[2:0]};
  endfunction

  function automatic int clsOf(logic [15:0] w);
    if (w[15:12] == 4'hF) return 2;
    if (w[11:9] == 3'd7) return 1;
    if (w[8:6] == 3'd2) return 3;
    return 0;
  endfunction

  function automatic int modeOf(logic [15:0] w);
    int o1 = int'(w[8:6]);
    int p  = int'(w[5:3]);
    int c  = clsOf(w);
    if (c == 1 || c == 2) return 0;
    if (o1 == 4) return (p >= 4) ? 9 : (p == 0 ? 5 : 5 + p);
    if (o1 == 5) return (p >= 4) ? 11 : 10;
    if (o1 == 6) return (p >= 4) ? 13 : 12;
    if (o1 == 7) return 14;
    return o1 + 1;
  endfunction

  function automatic int shiftOf(logic [15:0] w);
    int m = modeOf(w);
    if (m >= 9 && m <= 13) return (int'(w[5:3]) % 4) + 1;
    return 0;
  endfunction

  function automatic bit extOf(logic [15:0] w);
    int m = modeOf(w);
    if (m >= 6 && m <= 8) return 1;
    if (clsOf(w) == 2 && (w[8:6] == 3'd1 || w[8:6] == 3'd2)) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (scenario %s) %s: actual %0d expected %0d", tag, curReq, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("R7", "decValid", int'(decValid), int'(eValid));
    if (eValid) begin
      chk("R1", "op0", int'(decOp0), int'(eWord[15:12]));
      chk("R1", "regA", int'(decRegA), int'(eWord[11:9]));
      chk("R1", "op1", int'(decOp1), int'(eWord[8:6]));
      chk("R1", "opn", int'(decOpn), int'(eWord[5:3]));
      chk("R1", "regB", int'(decRegB), int'(eWord[2:0]));
      chk("R4", "class", int'(decClass), clsOf(eWord));
      chk("R5", "mode", int'(decMode), modeOf(eWord));
      chk("R6", "shift", int'(decShift), shiftOf(eWord));
      chk("R2", "ext", int'(decExt), int'(eExt));
      chk("R9", "imm", int'(decImm), int'(eImm));
    end
  endtask

  task automatic step(bit v, logic [15:0] w, bit r = 0);
    compare();
    rst = r;
    wordValid = v;
    wordIn = w;
    if (r) begin
      pend = 0;
      eValid = 0;
    end else if (v) begin
      if (pend) begin
        eValid = 1; eWord = held; eImm = w; eExt = 1; pend = 0;
      end else if (extOf(w)) begin
        pend = 1; held = w; eValid = 0;
      end else begin
        eValid = 1; eWord = w; eImm = '0; eExt = 0;
      end
    end else begin
      eValid = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    curReq = "R8";
    step(0, '0, 1);
    step(0, '0, 1);
    step(0, '0);
    // R1 R5: single-word addressing modes, back to back
    curReq = "R5";
    step(1, mk(0, 1, 1, 5, 2));
    step(1, mk(2, 3, 0, 7, 7));
    step(1, mk(8, 2, 3, 6, 4));
    step(1, mk(11, 5, 7, 1, 1));
    step(1, mk(9, 4, 4, 0, 3));
    step(0, '0);
    // R6: shifts
    curReq = "R6";
    step(1, mk(0, 1, 4, 5, 2));
    step(1, mk(10, 1, 5, 0, 2));
    step(1, mk(10, 1, 5, 7, 2));
    step(1, mk(12, 6, 6, 3, 0));
    step(1, mk(12, 6, 6, 4, 0));
    step(1, mk(3, 2, 4, 7, 1));
    // R2: two-word ALU forms with idle gaps (R7)
    curReq = "R2";
    step(1, mk(0, 3, 4, 1, 2));
    step(0, '0);
    step(0, '0);
    step(1, 16'hBEEF);
    step(1, mk(9, 1, 4, 2, 0));
    step(1, 16'h1234);
    step(1, mk(13, 2, 4, 3, 5));
    step(1, 16'h0000);
    step(1, mk(0, 0, 1, 0, 0));
    // R3: call and goto with target word; other special forms single word
    curReq = "R3";
    step(1, mk(15, 2, 1, 3, 5));
    step(1, 16'h8001);
    step(1, mk(15, 7, 2, 0, 0));
    step(0, '0);
    step(1, 16'hFFFF);
    step(1, mk(15, 3, 0, 1, 4));
    step(1, mk(15, 0, 5, 0, 1));
    // R4 R9: jumps (including op1=4 opn=1 bits) and stack list
    curReq = "R9";
    step(1, mk(5, 7, 1, 0, 3));
    step(1, mk(14, 7, 4, 1, 0));
    step(1, mk(0, 7, 4, 2, 7));
    curReq = "R4";
    step(1, mk(9, 5, 2, 2, 0));
    step(1, mk(13, 6, 2, 2, 0));
    step(1, mk(4, 7, 2, 2, 0));
    // R8: reset while waiting for a second word
    curReq = "R8";
    step(1, mk(1, 2, 4, 1, 3));
    step(1, 16'h5555, 1);
    step(1, mk(0, 1, 1, 2, 3));
    step(1, mk(15, 1, 1, 0, 0));
    step(0, '0, 1);
    step(1, mk(6, 4, 0, 3, 3));
    step(0, '0);
    step(0, '0);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule